// File: doc/BRIEF.md
# Refresh Scheduler with Postponement for a Two-Rank DDR Controller

The block decides when each rank of a DDR SDRAM controller needs an auto-refresh. A shared interval counter fires once every `REFI_CYCLES` controller clocks, which is 1560 cycles at a 5 ns clock, or 7.8 µs. Each firing adds one owed refresh to every rank that is not in self-refresh. The owed count saturates at `MAX_OWED`, which is 8. Any rank that owes refreshes raises a request. The controller may ignore that request while it has other work for the rank. When the debt reaches the limit, the request becomes urgent and the rank is blocked for all other commands until a refresh is granted.

The request is a valid/ready pair for each rank. `ref_req_o` is the valid signal and `ref_grant_i` is the ready signal. A refresh counts as issued in a cycle where both are high. The controller applies back-pressure by holding `ref_grant_i` low, and it may do so for as long as the request is not urgent. A grant in a cycle with no request has no effect. The request stays high until the owed count returns to zero, so postponed refreshes drain as a burst. Each refresh in the burst is separated from the next by the refresh cycle time.

The block also handles self-refresh for each rank. It accepts an entry request only when the rank's banks are all idle, and it drives the rank's clock-enable low while the rank is in self-refresh. After exit, it holds off activates and refreshes for one guard window and reads for a longer one. The block supplies no row address, because the device's internal counter provides it.

Top module: `rfsh_sched`

## Requirements
- R1: After reset, the first interval tick comes after `REFI_CYCLES` clocks, and later ticks follow every `REFI_CYCLES` clocks. Each tick adds one owed refresh to every rank not in self-refresh.
- R2: The owed count of a rank never exceeds `MAX_OWED`. A tick that arrives at the limit with no grant in the same cycle is dropped.
- R3: `ref_urgent_o[r]` is high exactly when rank r owes `MAX_OWED` refreshes. While it is high, `act_block_o[r]` is high.
- R4: `ref_req_o[r]` is high when rank r owes at least one refresh, is out of self-refresh, and has no tRFC or exit window running. A cycle with both request and grant high removes one owed refresh. A tick in that same cycle leaves the count unchanged.
- R5: A grant in a cycle where `ref_req_o[r]` is low changes nothing at the outputs.
- R6: For the `RFC_CYCLES` cycles after a granted refresh, `act_block_o[r]` is high and `ref_req_o[r]` is low.
- R7: A rank enters self-refresh on `sr_enter_i[r]` only when all of these hold: `banks_idle_i[r]` is high, the rank is not already in self-refresh, no tRFC window is running, and no refresh is being granted in that cycle. Entry clears the owed count. While the rank is in self-refresh, `cke_o[r]` is low and the rank raises no request.
- R8: `sr_exit_i[r]` during self-refresh drives `cke_o[r]` high. It then holds `act_block_o[r]` high, with `ref_req_o[r]` low, for `XSNR_CYCLES` cycles, and holds `rd_block_o[r]` high for `XSRD_CYCLES` cycles.
- R9: During and right after reset, every request, urgent and block output is low, and `cke_o` is all ones.
- R10: The ranks are independent. Grants and self-refresh controls on one rank do not affect the other rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_grant_i | input | RANKS | Controller accepts the refresh request (ready), one bit per rank |
| banks_idle_i | input | RANKS | All banks of the rank are precharged |
| sr_enter_i | input | RANKS | Request to enter self-refresh |
| sr_exit_i | input | RANKS | Request to leave self-refresh |
| ref_req_o | output | RANKS | Refresh owed and allowed (valid) |
| ref_urgent_o | output | RANKS | Owed count at the postponement limit |
| cke_o | output | RANKS | Clock-enable; low while the rank is in self-refresh |
| act_block_o | output | RANKS | No activate or other non-refresh command may go to the rank |
| rd_block_o | output | RANKS | No read may go to the rank |

## Verification
The bench builds the block with `REFI_CYCLES`=20, `RFC_CYCLES`=3, `XSNR_CYCLES`=4 and `XSRD_CYCLES`=10. `MAX_OWED` stays at 8 and the rank count stays at 2. With the short interval, the rank reaches saturation and urgency within a few hundred cycles. The short guard windows let one run cover a postponed burst drain, grants arriving at the same time as ticks, self-refresh entry attempts that must be refused, and the end of each exit window. A behavioural model tracks the owed count and the window counters for each rank and is compared with every output on every clock.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  // Per-rank status bundle passed from a rank slice to the top.
  typedef struct packed {
    logic req;
    logic urgent;
    logic cke;
    logic act_block;
    logic rd_block;
  } rank_stat_t;
endpackage

// File: rtl/rfsh_tick.sv
module rfsh_tick #(
  parameter int REFI_CYCLES = 1560
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (REFI_CYCLES > 2) ? $clog2(REFI_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(REFI_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R1
endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int SPAN = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(SPAN + 1);
  localparam logic [CW-1:0] START = CW'(SPAN);

  logic [CW-1:0] left_q;

  assign busy_o = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left_q <= '0;
    else if (load_i) left_q <= START;
    else if (busy_o) left_q <= left_q - 1'b1;
  end

  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> busy_o); // R6
endmodule

// File: rtl/rfsh_credit.sv
module rfsh_credit #(
  parameter int MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic fire_i,
  input  logic clear_i,
  output logic [$clog2(MAX_OWED+1)-1:0] owed_o,
  output logic full_o,
  output logic some_o
);
  localparam int OW = $clog2(MAX_OWED + 1);
  localparam logic [OW-1:0] TOP = OW'(MAX_OWED);

  logic [OW-1:0] owed_q, owed_d;

  assign owed_o = owed_q;
  assign full_o = (owed_q == TOP);
  assign some_o = (owed_q != '0);

  always_comb begin
    owed_d = owed_q;
    if (clear_i) begin
      owed_d = '0;
    end else begin
      unique case ({tick_i, fire_i})
        2'b10:   if (!full_o) owed_d = owed_q + 1'b1;
        2'b01:   if (some_o)  owed_d = owed_q - 1'b1;
        default: owed_d = owed_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else        owed_q <= owed_d;
  end

  AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q <= TOP); // R2
  AST_FIRE_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !tick_i && !clear_i && some_o) |=> (owed_q == $past(owed_q) - 1'b1)); // R4
endmodule

// File: rtl/rfsh_rank.sv
module rfsh_rank
  import rfsh_pkg::*;
#(
  parameter int MAX_OWED    = 8,
  parameter int RFC_CYCLES  = 14,
  parameter int XSNR_CYCLES = 14,
  parameter int XSRD_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       grant_i,
  input  logic       idle_i,
  input  logic       sr_enter_i,
  input  logic       sr_exit_i,
  output rank_stat_t stat_o
);
  localparam int OW = $clog2(MAX_OWED + 1);

  logic [OW-1:0] owed;
  logic full, some;
  logic in_sr_q;
  logic rfc_busy, xsnr_busy, xsrd_busy;
  logic req, fire, enter, leave;

  assign req   = some && !in_sr_q && !rfc_busy && !xsnr_busy;
  assign fire  = req && grant_i;
  assign enter = sr_enter_i && idle_i && !in_sr_q && !rfc_busy && !fire;
  assign leave = sr_exit_i && in_sr_q;

  rfsh_credit #(.MAX_OWED(MAX_OWED)) u_credit (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .fire_i  (fire),
    .clear_i (enter || in_sr_q),
    .owed_o  (owed),
    .full_o  (full),
    .some_o  (some)
  );

  rfsh_timer #(.SPAN(RFC_CYCLES)) u_rfc (
    .clk(clk), .rst_n(rst_n), .load_i(fire), .busy_o(rfc_busy)
  );
  rfsh_timer #(.SPAN(XSNR_CYCLES)) u_xsnr (
    .clk(clk), .rst_n(rst_n), .load_i(leave), .busy_o(xsnr_busy)
  );
  rfsh_timer #(.SPAN(XSRD_CYCLES)) u_xsrd (
    .clk(clk), .rst_n(rst_n), .load_i(leave), .busy_o(xsrd_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     in_sr_q <= 1'b0;
    else if (enter) in_sr_q <= 1'b1;
    else if (leave) in_sr_q <= 1'b0;
  end

  always_comb begin
    stat_o.req       = req;
    stat_o.urgent    = full;
    stat_o.cke       = !in_sr_q;
    stat_o.act_block = in_sr_q || rfc_busy || xsnr_busy || full;
    stat_o.rd_block  = stat_o.act_block || xsrd_busy;
  end

  AST_NO_REQ_IN_SR: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr_q |-> !req); // R7
  AST_SR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sr_q) |-> (owed == '0)); // R7
  AST_NO_ENTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_i && !in_sr_q) |=> !in_sr_q); // R7
  AST_URGENT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o.urgent |-> stat_o.act_block); // R3
  AST_EXIT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    leave |=> (xsnr_busy && xsrd_busy && !req)); // R8
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int RANKS       = 2,
  parameter int REFI_CYCLES = 1560,
  parameter int MAX_OWED    = 8,
  parameter int RFC_CYCLES  = 14,
  parameter int XSNR_CYCLES = 14,
  parameter int XSRD_CYCLES = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RANKS-1:0] ref_grant_i,
  input  logic [RANKS-1:0] banks_idle_i,
  input  logic [RANKS-1:0] sr_enter_i,
  input  logic [RANKS-1:0] sr_exit_i,
  output logic [RANKS-1:0] ref_req_o,
  output logic [RANKS-1:0] ref_urgent_o,
  output logic [RANKS-1:0] cke_o,
  output logic [RANKS-1:0] act_block_o,
  output logic [RANKS-1:0] rd_block_o
);
  logic tick;
  rank_stat_t stat [RANKS];

  rfsh_tick #(.REFI_CYCLES(REFI_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    rfsh_rank #(
      .MAX_OWED    (MAX_OWED),
      .RFC_CYCLES  (RFC_CYCLES),
      .XSNR_CYCLES (XSNR_CYCLES),
      .XSRD_CYCLES (XSRD_CYCLES)
    ) u_rank (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick),
      .grant_i    (ref_grant_i[r]),
      .idle_i     (banks_idle_i[r]),
      .sr_enter_i (sr_enter_i[r]),
      .sr_exit_i  (sr_exit_i[r]),
      .stat_o     (stat[r])
    );
    assign ref_req_o[r]    = stat[r].req;
    assign ref_urgent_o[r] = stat[r].urgent;
    assign cke_o[r]        = stat[r].cke;
    assign act_block_o[r]  = stat[r].act_block;
    assign rd_block_o[r]   = stat[r].rd_block;
  end
endmodule

// File: tb/sim_rfsh_sched.sv
`timescale 1ns/1ps
module sim_rfsh_sched;
  localparam int NR   = 2;
  localparam int REFI = 20;
  localparam int MAXO = 8;
  localparam int RFC  = 3;
  localparam int XSNR = 4;
  localparam int XSRD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic [NR-1:0] grant = '0, idle = '0, sr_in = '0, sr_out = '0;
  logic [NR-1:0] req, urg, cke, actb, rdb;

  int total = 0;
  int bad = 0;
  bit in_reset = 1;

  always #4 clk = ~clk;

  rfsh_sched #(
    .RANKS(NR), .REFI_CYCLES(REFI), .MAX_OWED(MAXO),
    .RFC_CYCLES(RFC), .XSNR_CYCLES(XSNR), .XSRD_CYCLES(XSRD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ref_grant_i(grant), .banks_idle_i(idle),
    .sr_enter_i(sr_in), .sr_exit_i(sr_out),
    .ref_req_o(req), .ref_urgent_o(urg), .cke_o(cke),
    .act_block_o(actb), .rd_block_o(rdb)
  );

  // Behavioural reference model
  int m_tc = 0;
  int m_owed [NR] = '{default: 0};
  int m_rfc  [NR] = '{default: 0};
  int m_xsnr [NR] = '{default: 0};
  int m_xsrd [NR] = '{default: 0};
  bit m_sr   [NR] = '{default: 0};

  function automatic bit m_req(int r);
    return (m_owed[r] > 0) && !m_sr[r] && (m_rfc[r] == 0) && (m_xsnr[r] == 0);
  endfunction
  function automatic bit m_act(int r);
    return m_sr[r] || (m_rfc[r] > 0) || (m_xsnr[r] > 0) || (m_owed[r] == MAXO);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tc = 0;
      for (int r = 0; r < NR; r++) begin
        m_owed[r] = 0; m_rfc[r] = 0; m_xsnr[r] = 0; m_xsrd[r] = 0; m_sr[r] = 0;
      end
    end else begin
      bit tk;
      tk = (m_tc == REFI - 1);
      for (int r = 0; r < NR; r++) begin
        bit fire, ent, ext;
        fire = m_req(r) && grant[r];
        ent  = sr_in[r] && idle[r] && !m_sr[r] && (m_rfc[r] == 0) && !fire;
        ext  = sr_out[r] && m_sr[r];
        if (ent || m_sr[r]) m_owed[r] = 0;
        else begin
          m_owed[r] = m_owed[r] + (tk ? 1 : 0) - (fire ? 1 : 0);
          if (m_owed[r] > MAXO) m_owed[r] = MAXO;
        end
        m_rfc[r]  = fire ? RFC  : (m_rfc[r]  > 0 ? m_rfc[r]  - 1 : 0);
        m_xsnr[r] = ext  ? XSNR : (m_xsnr[r] > 0 ? m_xsnr[r] - 1 : 0);
        m_xsrd[r] = ext  ? XSRD : (m_xsrd[r] > 0 ? m_xsrd[r] - 1 : 0);
        if (ent) m_sr[r] = 1;
        else if (ext) m_sr[r] = 0;
      end
      m_tc = tk ? 0 : m_tc + 1;
    end
  end

  task automatic chk(string tag, int r, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s rank%0d t=%0t: actual=%0b expected=%0b", tag, r, $time, act, exp);
    end
  endtask

  // Compare every output of every rank on every cycle, away from the edge
  always @(negedge clk) begin
    #2;
    for (int r = 0; r < NR; r++) begin
      if (in_reset) begin
        chk("R9 req", r, req[r], 1'b0);
        chk("R9 cke", r, cke[r], 1'b1);
        chk("R9 act_block", r, actb[r], 1'b0);
        chk("R9 rd_block", r, rdb[r], 1'b0);
        chk("R9 urgent", r, urg[r], 1'b0);
      end else begin
        chk("R1 R2 R4 R5 R6 R10 req", r, req[r], m_req(r));
        chk("R2 R3 urgent", r, urg[r], m_owed[r] == MAXO);
        chk("R7 R8 cke", r, cke[r], !m_sr[r]);
        chk("R3 R6 R8 act_block", r, actb[r], m_act(r));
        chk("R8 rd_block", r, rdb[r], m_act(r) || (m_xsrd[r] > 0));
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 0;

  initial begin
    step(4);
    rst_n = 1;
    step(1);
    in_reset = 0;
    // R1: owed refreshes pile up with no grants
    step(65);
    // R4 R6: drain rank0 as a burst, rank1 left alone (R10)
    grant[0] = 1; step(25); grant[0] = 0;
    // R5: grant with no request pending
    grant[0] = 1; step(5); grant[0] = 0;
    // R2 R3: saturate both ranks, urgent and blocked
    step(230);
    // R4: drain rank1 fully, rank0 stays urgent (R10)
    grant[1] = 1; step(45); grant[1] = 0;
    // R7: entry refused while banks are busy
    sr_in[1] = 1; step(3); sr_in[1] = 0; step(2);
    // R7: entry refused during tRFC, then accepted
    idle[0] = 1; grant[0] = 1; step(1); grant[0] = 0; sr_in[0] = 1; step(1);
    step(4); sr_in[0] = 0;
    step(60);
    // R8: exit and guard windows
    sr_out[0] = 1; step(1); sr_out[0] = 0;
    step(30);
    // R7 R8 R10: rank1 enters and leaves while rank0 runs normally
    idle[1] = 1; sr_in[1] = 1; step(1); sr_in[1] = 0; step(40);
    sr_out[1] = 1; step(1); sr_out[1] = 0; step(25);
    // Mixed pattern
    for (int i = 0; i < 400; i++) begin
      grant  = 2'($urandom_range(0, 3));
      idle   = 2'($urandom_range(0, 3));
      sr_in  = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      sr_out = ($urandom_range(0, 11) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      step(1);
    end
    grant = '0; sr_in = '0; sr_out = '0;
    step(5);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule